// File: doc/BRIEF.md
# Multi-Mode Timer/Event Counter

This block is an 8-bit up counter for a small controller. A two-bit mode field picks what it counts: ticks of a prescaled internal clock, active edges on an external input pin, or the duration of a pulse on that pin. The prescaler is a free-running divider ahead of the counter, and a three-bit field sets its ratio to a power of two. When the counter steps past its all-ones value, it reloads from a writable preload register. It also raises an interrupt request flag and sends a one-cycle wake request to the power manager.

Software writes either the control register or the preload register through a single write port. It reads the live count from the counter port. In pulse-width mode, one measurement disarms the counter by itself: the enable bit drops on the trailing edge of the pulse, so the count holds the pulse length until software reads it and re-arms the counter.

Control register layout: bits 7:6 mode (00 idle, 01 event count, 10 timer, 11 pulse width), bit 5 reserved (reads as written 0), bit 4 enable, bit 3 polarity select, bits 2:0 prescaler exponent n.

Top module: `evtmr_top`

## Requirements
- R1: After reset the count is 0x00, the interrupt flag and wake request are low, and the control and preload registers are zero, so the mode is 00 and the counter is stopped.
- R2: In mode 10 with enable (bit 4) set, the count rises by exactly one on each prescaler strobe. tick_o is high one cycle in every 2^n, where n is control bits 2:0, so over any 64 cycles the count rises 64/2^n times when no wrap occurs.
- R3: While enable is 0 the count holds. A write with wr_sel=1 while enable is 0 updates the preload register and also copies the data into the count. While enable is 1 it updates only the preload register.
- R4: In mode 00 the count never changes, even with enable set.
- R5: A step from 0xFF reloads the count from the preload register, sets ovf_flag_o and pulses wake_o high for that one cycle. The flag stays set until irq_ack is high at a clock edge, and a new overflow on that edge wins over the clear.
- R6: In mode 01 with enable set, the count rises once per active edge of ext_in after a two-stage synchronizer (three clock edges from pin to count). Control bit 3 = 0 selects rising edges and 1 selects falling edges.
- R7: In mode 11 with enable set, the count rises on each prescaler strobe while ext_in is at its active level (high when bit 3 = 0, low when bit 3 = 1). On the trailing edge, enable clears itself, so later pulses are not counted.
- R8: In modes 01 and 10, enable stays set whatever ext_in does and is cleared only by a control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 preload |
| wr_data | input | 8 | Write data |
| ext_in | input | 1 | External timer input pin (asynchronous) |
| irq_ack | input | 1 | Clears the overflow interrupt flag |
| cnt_o | output | 8 | Current count |
| tick_o | output | 1 | Prescaled internal clock enable |
| ovf_flag_o | output | 1 | Overflow interrupt request flag |
| wake_o | output | 1 | One-cycle wake request on overflow |

## Verification
A wrong prescaler phase or exponent shows on tick_o in the same cycle, and on cnt_o one edge later. A synchronizer or edge-detect fault moves the count away from the expected value three edges after an ext_in change. A missed self-clear in pulse mode shows only when a second pulse arrives and the count moves. Overflow faults show on wake_o and ovf_flag_o on the wrap edge itself, so a cycle-by-cycle reference model catches every such deviation at the first cycle it appears.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'b00,
        MODE_EVENT = 2'b01,
        MODE_TIMER = 2'b10,
        MODE_PULSE = 2'b11
    } tmr_mode_e;

    localparam int PSEL_W = 3;

    typedef struct packed {
        tmr_mode_e           mode;
        logic                rsvd;
        logic                en;
        logic                fall_sel;
        logic [PSEL_W-1:0]   psel;
    } tmr_ctrl_t;

endpackage

// File: rtl/evtmr_presc.sv
module evtmr_presc #(
    parameter int STAGES = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [evtmr_pkg::PSEL_W-1:0]      psel,
    output logic                              tick
);
    localparam int PW = STAGES - 1;

    typedef struct packed {
        logic [PW-1:0] div;
    } presc_st_t;

    presc_st_t st_q, st_d;
    logic [PW-1:0] mask;

    always_comb begin
        st_d     = st_q;
        st_d.div = st_q.div + 1'b1;
        for (int i = 0; i < PW; i++) begin
            mask[i] = (i < int'(psel));
        end
        tick = &(st_q.div | ~mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/evtmr_insync.sv
module evtmr_insync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    input  logic fall_sel,
    output logic act_edge,
    output logic lvl_act,
    output logic trail
);
    localparam int SW = SYNC_STAGES + 1;

    typedef struct packed {
        logic [SW-1:0] sh;
    } sync_st_t;

    sync_st_t st_q, st_d;
    logic level, prev, raw_rise, raw_fall;

    always_comb begin
        st_d.sh  = {st_q.sh[SW-2:0], ext_in};
        level    = st_q.sh[SYNC_STAGES-1];
        prev     = st_q.sh[SYNC_STAGES];
        raw_rise = level & ~prev;
        raw_fall = ~level & prev;
        act_edge = fall_sel ? raw_fall : raw_rise;
        trail    = fall_sel ? raw_rise : raw_fall;
        lvl_act  = level ^ fall_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/evtmr_regs.sv
module evtmr_regs #(
    parameter int CNT_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   wr_sel,
    input  logic [CNT_W-1:0]       wr_data,
    input  logic                   en_clr,
    output evtmr_pkg::tmr_ctrl_t   ctrl,
    output logic [CNT_W-1:0]       preload,
    output logic                   load_cnt
);
    import evtmr_pkg::*;

    typedef struct packed {
        tmr_ctrl_t        ctrl;
        logic [CNT_W-1:0] pre;
    } regs_st_t;

    regs_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (wr_en && !wr_sel) begin
            st_d.ctrl      = tmr_ctrl_t'(wr_data[7:0]);
            st_d.ctrl.rsvd = 1'b0;
        end else if (en_clr) begin
            st_d.ctrl.en   = 1'b0;
        end
        if (wr_en && wr_sel) st_d.pre = wr_data;
        load_cnt = wr_en && wr_sel && !st_q.ctrl.en;
        ctrl     = st_q.ctrl;
        preload  = st_q.pre;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/evtmr_core.sv
module evtmr_core #(
    parameter int CNT_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  evtmr_pkg::tmr_mode_e   mode,
    input  logic                   en,
    input  logic                   tick,
    input  logic                   act_edge,
    input  logic                   lvl_act,
    input  logic                   trail,
    input  logic                   load,
    input  logic [CNT_W-1:0]       load_val,
    input  logic [CNT_W-1:0]       preload,
    input  logic                   irq_ack,
    output logic [CNT_W-1:0]       cnt,
    output logic                   ovf,
    output logic                   wake,
    output logic                   en_clr
);
    import evtmr_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        logic             wake;
    } core_st_t;

    core_st_t st_q, st_d;
    logic step, wrap;

    always_comb begin
        unique case (mode)
            MODE_EVENT: step = en && act_edge;
            MODE_TIMER: step = en && tick;
            MODE_PULSE: step = en && tick && lvl_act;
            default:    step = 1'b0;
        endcase
        wrap   = step && (st_q.cnt == CNT_MAX);
        en_clr = en && (mode == MODE_PULSE) && trail;

        st_d      = st_q;
        st_d.wake = wrap;
        st_d.ovf  = wrap | (st_q.ovf & ~irq_ack);
        if (load)      st_d.cnt = load_val;
        else if (wrap) st_d.cnt = preload;
        else if (step) st_d.cnt = st_q.cnt + 1'b1;

        cnt  = st_q.cnt;
        ovf  = st_q.ovf;
        wake = st_q.wake;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/evtmr_top.sv
module evtmr_top #(
    parameter int CNT_W       = 8,
    parameter int PS_STAGES   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             ext_in,
    input  logic             irq_ack,
    output logic [CNT_W-1:0] cnt_o,
    output logic             tick_o,
    output logic             ovf_flag_o,
    output logic             wake_o
);
    import evtmr_pkg::*;

    tmr_ctrl_t        ctrl;
    logic [CNT_W-1:0] preload;
    logic             load_cnt, en_clr;
    logic             act_edge, lvl_act, trail;

    evtmr_regs #(.CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .en_clr(en_clr), .ctrl(ctrl),
        .preload(preload), .load_cnt(load_cnt)
    );

    evtmr_presc #(.STAGES(PS_STAGES)) presc_i (
        .clk(clk), .rst_n(rst_n), .psel(ctrl.psel), .tick(tick_o)
    );

    evtmr_insync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .fall_sel(ctrl.fall_sel),
        .act_edge(act_edge), .lvl_act(lvl_act), .trail(trail)
    );

    evtmr_core #(.CNT_W(CNT_W)) core_i (
        .clk(clk), .rst_n(rst_n), .mode(ctrl.mode), .en(ctrl.en),
        .tick(tick_o), .act_edge(act_edge), .lvl_act(lvl_act), .trail(trail),
        .load(load_cnt), .load_val(wr_data), .preload(preload),
        .irq_ack(irq_ack), .cnt(cnt_o), .ovf(ovf_flag_o), .wake(wake_o),
        .en_clr(en_clr)
    );
endmodule

// File: rtl/evtmr_chk.sv
module evtmr_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_sel,
    input logic             irq_ack,
    input logic [CNT_W-1:0] cnt,
    input logic             ovf,
    input logic             wake,
    input logic [1:0]       mode,
    input logic             en,
    input logic [CNT_W-1:0] preload
);
    AST_WAKE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> ovf); // R5

    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (cnt == $past(preload))); // R5

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_ack) && !wake) |-> !ovf); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'b00 && !$past(wr_en)) |-> $stable(cnt)); // R4

    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(en) && !($past(wr_en) && $past(wr_sel))) |-> $stable(cnt)); // R3

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake && !$past(wr_en)) |-> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1)); // R2
endmodule

bind evtmr_top evtmr_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .irq_ack(irq_ack), .cnt(cnt_o), .ovf(ovf_flag_o), .wake(wake_o),
    .mode(ctrl.mode), .en(ctrl.en), .preload(preload)
);

// File: tb/evtmr_tb_top.sv
module evtmr_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_sel = 1'b0, ext_in = 1'b0, irq_ack = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] cnt_o;
    logic       tick_o, ovf_flag_o, wake_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evtmr_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ext_in(ext_in), .irq_ack(irq_ack),
        .cnt_o(cnt_o), .tick_o(tick_o), .ovf_flag_o(ovf_flag_o), .wake_o(wake_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- reference model built from the requirements ----------
    logic [1:0] m_s;
    logic       m_p;
    logic [6:0] m_ps;
    logic [7:0] m_ctrl, m_pre, m_cnt;
    logic       m_ovf, m_wake;
    logic       m_tick, m_edge, m_lvl, m_trail, m_step, m_en, m_load, m_clr;
    logic [1:0] m_mode;

    always_comb begin
        m_mode  = m_ctrl[7:6];
        m_en    = m_ctrl[4];
        m_tick  = ((m_ps | ~(7'h7f >> (7 - m_ctrl[2:0]))) == 7'h7f);
        m_edge  = m_ctrl[3] ? (!m_s[1] && m_p) : (m_s[1] && !m_p);
        m_trail = m_ctrl[3] ? (m_s[1] && !m_p) : (!m_s[1] && m_p);
        m_lvl   = m_s[1] ^ m_ctrl[3];
        m_step  = m_en && ((m_mode == 2'b01 && m_edge) || (m_mode == 2'b10 && m_tick) ||
                           (m_mode == 2'b11 && m_tick && m_lvl));
        m_load  = wr_en && wr_sel && !m_en;
        m_clr   = m_en && m_mode == 2'b11 && m_trail;
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s <= '0; m_p <= 1'b0; m_ps <= '0; m_ctrl <= '0; m_pre <= '0;
            m_cnt <= '0; m_ovf <= 1'b0; m_wake <= 1'b0;
        end else begin
            m_s  <= {m_s[0], ext_in};
            m_p  <= m_s[1];
            m_ps <= m_ps + 7'd1;
            if (wr_en && !wr_sel) m_ctrl <= wr_data & 8'hdf;
            else if (m_clr)       m_ctrl[4] <= 1'b0;
            if (wr_en && wr_sel)  m_pre <= wr_data;
            m_wake <= m_step && m_cnt == 8'hff;
            m_ovf  <= (m_step && m_cnt == 8'hff) || (m_ovf && !irq_ack);
            if (m_load)                          m_cnt <= wr_data;
            else if (m_step && m_cnt == 8'hff)   m_cnt <= m_pre;
            else if (m_step)                     m_cnt <= m_cnt + 8'd1;
        end
    end

    function automatic string mode_req(input logic [1:0] md);
        case (md)
            2'b01:   return "R6";
            2'b10:   return "R2";
            2'b11:   return "R7";
            default: return "R4";
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(mode_req(m_mode), "model count", int'(cnt_o), int'(m_cnt));
            check("R5", "model flag", int'(ovf_flag_o), int'(m_ovf));
            check("R5", "model wake", int'(wake_o), int'(m_wake));
            check("R2", "model tick", int'(tick_o), int'(m_tick));
        end
    end

    // ---------------- stimulus helpers -------------------------------------
    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog run did not end actual=%0d expected=0", WD_CYCLES);
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] c0, c1;
        void'($urandom(32'h5eed_0042));
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        check("R1", "reset count", int'(cnt_o), 0);
        check("R1", "reset flag", int'(ovf_flag_o), 0);
        check("R1", "reset wake", int'(wake_o), 0);

        // R4 idle mode with enable set
        wr(1'b0, 8'h10);
        cyc(20);
        check("R4", "idle mode holds", int'(cnt_o), 0);

        // R3 preload write while stopped loads count
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h10);
        check("R3", "stopped preload loads count", int'(cnt_o), 8'h10);

        // R2 timer n=3: eight steps per 64 cycles
        wr(1'b0, 8'h93);
        cyc(4);
        c0 = cnt_o;
        cyc(64);
        c1 = cnt_o;
        check("R2", "timer rate n=3", int'(c1 - c0), 8);

        // R8 enable survives input activity in timer mode
        repeat (6) begin ext_in = ~ext_in; cyc(5); end
        ext_in = 1'b0;
        c0 = cnt_o;
        cyc(40);
        check("R8", "timer still running", int'(cnt_o - c0), 5);

        // R3 preload write while running does not touch count
        @(negedge clk);
        c0 = cnt_o;
        wr(1'b1, 8'h77);
        check("R3", "running preload write", int'(cnt_o == 8'h77), 0);

        // R3 stop holds
        wr(1'b0, 8'h83);
        c0 = cnt_o;
        cyc(20);
        check("R3", "stopped holds", int'(cnt_o), int'(c0));

        // R5 overflow with preload reload
        wr(1'b0, 8'h80);
        wr(1'b1, 8'hfe);
        wr(1'b0, 8'h90);
        for (int i = 0; i < 10 && !wake_o; i++) cyc(1);
        check("R5", "wake pulse", int'(wake_o), 1);
        check("R5", "reload value", int'(cnt_o), 8'hfe);
        wr(1'b0, 8'h80);
        cyc(5);
        check("R5", "flag held", int'(ovf_flag_o), 1);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        check("R5", "flag cleared by ack", int'(ovf_flag_o), 0);

        // R6 event count rising edges
        wr(1'b0, 8'h40);
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h50);
        repeat (5) begin ext_in = 1'b1; cyc(4); ext_in = 1'b0; cyc(4); end
        cyc(5);
        check("R6", "rising edges counted", int'(cnt_o), 5);
        check("R8", "event enable kept", int'(cnt_o != 0), 1);

        // R6 falling edge select
        wr(1'b0, 8'h48);
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h58);
        ext_in = 1'b1; cyc(6);
        check("R6", "rising ignored with falling select", int'(cnt_o), 0);
        ext_in = 1'b0; cyc(6);
        check("R6", "falling edge counted", int'(cnt_o), 1);

        // R7 pulse width with self-clearing enable
        wr(1'b0, 8'hc0);
        wr(1'b1, 8'h00);
        wr(1'b0, 8'hd0);
        cyc(5);
        check("R7", "inactive level no count", int'(cnt_o), 0);
        ext_in = 1'b1; cyc(10); ext_in = 1'b0; cyc(6);
        check("R7", "pulse width measured", int'(cnt_o), 10);
        ext_in = 1'b1; cyc(10); ext_in = 1'b0; cyc(6);
        check("R7", "second pulse ignored", int'(cnt_o), 10);

        // random phase against the model
        for (int i = 0; i < 4000; i++) begin
            int r;
            @(negedge clk);
            r = int'($urandom % 100);
            wr_en   = (r < 4);
            wr_sel  = (r >= 2);
            wr_data = (r < 2) ? ((8'($urandom) & 8'hcf) | 8'h10) : 8'($urandom);
            if ($urandom % 6 == 0) ext_in = ~ext_in;
            irq_ack = ($urandom % 20 == 0);
        end
        @(negedge clk);
        wr_en = 1'b0; irq_ack = 1'b0;
        cyc(2);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule